// File: doc/BRIEF.md
# Count-Triggered Transmit Frame Buffer

The block gathers one outgoing frame that a host writes into a data port, one byte per write strobe. Before the bytes arrive, the host programs the intended frame length into a length register. When the number of bytes written equals that length, or reaches the buffer capacity of 1514 bytes, the block freezes the frame. It then plays the frame out on a byte stream with valid, data and last. When the downstream side takes the final byte, the block emits a one-cycle completion pulse.

While a frame is being played out, the block holds a busy flag high and discards data-port writes. The length register is cleared when a frame is sent, so the host programs it again for each frame. A length above the capacity is replaced by zero. With a length of zero, a frame is sent only when the buffer is full.

Top module: `tx_frame_buffer`

## Requirements
- R1: A length write with a value from 0 to 1514 stores that value, and `len_rd` shows it from the next cycle.
- R2: A length write with a value above 1514 stores zero.
- R3: Each accepted data write stores its byte at the current fill position and advances the position. Bytes leave the stream in the order they were written.
- R4: A frame is sent when the count of bytes written reaches the programmed nonzero length. The frame carries exactly that many bytes.
- R5: With a stored length of zero, no frame is sent before 1514 bytes have been written, and the 1514th byte sends a frame of 1514 bytes.
- R6: The write that sends a frame clears the stored length to zero. The next frame fills from position zero.
- R7: `busy` and `tx_valid` are high from the cycle after the sending write until the final byte is accepted. Data writes made while `busy` is high are discarded.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. The stream advances one byte on each cycle with both valid and ready high.
- R9: `tx_last` is high only on the final byte of a frame.
- R10: `tx_done` is high for exactly one cycle, the cycle after the final byte is accepted, and `busy` is low in that cycle.
- R11: A length write that lands in the same cycle as the sending data write is kept: the write wins over the clear, and it applies to the next frame.
- R12: After reset, `len_rd` is 0 and `busy`, `tx_valid` and `tx_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_wr | input | 1 | Length register write strobe |
| len_wdata | input | 16 | Length value to write |
| len_rd | output | 11 | Stored length readback |
| byte_wr | input | 1 | Data port write strobe |
| byte_wdata | input | 8 | Data byte to append |
| busy | output | 1 | Frame is being played out |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_done | output | 1 | One-cycle frame completion pulse |

## Verification
A length write can coincide with the data write that sends a frame. In that cycle the clear that belongs to the outgoing frame meets the new length that belongs to the next one. The bench drives both strobes on the same edge. It then reads the length back, expecting the new value and not zero, and sends a second frame of that length to confirm the value took effect. The same bench also writes bytes while a frame is stalled by a low ready, and judges them from the content of the next frame.

// File: rtl/txfb_pkg.sv
package txfb_pkg;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_SEND = 1'b1
    } txfb_phase_e;

endpackage

// File: rtl/txfb_len_reg.sv
module txfb_len_reg #(
    parameter int CAPACITY = 1514,
    parameter int IN_W     = 16,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IN_W-1:0]  wr_val,
    input  logic             clr,
    output logic [CNT_W-1:0] len_q
);

    logic [CNT_W-1:0] len_d;
    logic             in_range;

    assign in_range = (32'(wr_val) <= CAPACITY);

    always_comb begin
        len_d = len_q;
        if (wr_en) begin
            len_d = in_range ? wr_val[CNT_W-1:0] : '0;
        end else if (clr) begin
            len_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    assert_len_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(len_q) <= CAPACITY);

    assert_oversize_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (32'(wr_val) > CAPACITY) |=> len_q == '0);

    assert_write_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && clr && (32'(wr_val) <= CAPACITY) |=> 32'(len_q) == 32'($past(wr_val)));

endmodule

// File: rtl/txfb_frame_mem.sv
module txfb_frame_mem #(
    parameter int DEPTH  = 1514,
    parameter int DATA_W = 8,
    parameter int AW     = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];

    assert_addr_in_depth_R3: assert property (@(posedge clk)
        we |-> 32'(waddr) < DEPTH);

endmodule

// File: rtl/txfb_ctrl.sv
module txfb_ctrl
    import txfb_pkg::*;
#(
    parameter int CAPACITY = 1514,
    parameter int CNT_W    = 11,
    parameter int AW       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_wr,
    input  logic [CNT_W-1:0] len_q,
    input  logic             tx_ready,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [AW-1:0]    mem_raddr,
    output logic             send_now,
    output logic             busy,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             tx_done
);

    typedef struct packed {
        txfb_phase_e     phase;
        logic [AW-1:0]   fill_idx;
        logic [AW-1:0]   play_idx;
        logic [AW-1:0]   final_idx;
        logic            done;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic [CNT_W-1:0] filled_next;
    logic             hit_len;
    logic             hit_cap;

    assign filled_next = CNT_W'(st_q.fill_idx) + CNT_W'(1);
    assign hit_len     = (filled_next == len_q);
    assign hit_cap     = (32'(filled_next) == CAPACITY);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        mem_we    = 1'b0;
        send_now  = 1'b0;
        unique case (st_q.phase)
            PH_FILL: begin
                if (byte_wr) begin
                    mem_we = 1'b1;
                    if (hit_len || hit_cap) begin
                        send_now       = 1'b1;
                        st_d.final_idx = st_q.fill_idx;
                        st_d.fill_idx  = '0;
                        st_d.play_idx  = '0;
                        st_d.phase     = PH_SEND;
                    end else begin
                        st_d.fill_idx = st_q.fill_idx + AW'(1);
                    end
                end
            end
            PH_SEND: begin
                if (tx_ready) begin
                    if (st_q.play_idx == st_q.final_idx) begin
                        st_d.phase = PH_FILL;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.play_idx = st_q.play_idx + AW'(1);
                    end
                end
            end
            default: st_d.phase = PH_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_FILL, fill_idx: '0, play_idx: '0, final_idx: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_waddr = st_q.fill_idx;
    assign mem_raddr = st_q.play_idx;
    assign busy      = (st_q.phase == PH_SEND);
    assign tx_valid  = busy;
    assign tx_last   = busy && (st_q.play_idx == st_q.final_idx);
    assign tx_done   = st_q.done;

    assert_no_store_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);

    assert_send_then_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        send_now |=> busy && tx_valid && mem_waddr == '0);

    assert_fill_below_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(mem_waddr) < CAPACITY);

    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> tx_done && !busy);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

endmodule

// File: rtl/tx_frame_buffer.sv
module tx_frame_buffer #(
    parameter int CAPACITY = 1514,
    parameter int DATA_W   = 8,
    parameter int LEN_IN_W = 16,
    parameter int LEN_W    = $clog2(CAPACITY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_wr,
    input  logic [LEN_IN_W-1:0] len_wdata,
    output logic [LEN_W-1:0]  len_rd,
    input  logic              byte_wr,
    input  logic [DATA_W-1:0] byte_wdata,
    output logic              busy,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              tx_done
);

    localparam int AW = $clog2(CAPACITY);

    logic            send_now;
    logic            mem_we;
    logic [AW-1:0]   mem_waddr;
    logic [AW-1:0]   mem_raddr;

    txfb_len_reg #(
        .CAPACITY (CAPACITY),
        .IN_W     (LEN_IN_W),
        .CNT_W    (LEN_W)
    ) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (len_wr),
        .wr_val (len_wdata),
        .clr    (send_now),
        .len_q  (len_rd)
    );

    txfb_ctrl #(
        .CAPACITY (CAPACITY),
        .CNT_W    (LEN_W),
        .AW       (AW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_wr   (byte_wr),
        .len_q     (len_rd),
        .tx_ready  (tx_ready),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_raddr (mem_raddr),
        .send_now  (send_now),
        .busy      (busy),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_done   (tx_done)
    );

    txfb_frame_mem #(
        .DEPTH  (CAPACITY),
        .DATA_W (DATA_W),
        .AW     (AW)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (byte_wdata),
        .raddr (mem_raddr),
        .rdata (tx_data)
    );

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    assert_last_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_idle_after_reset_R12: assert property (@(posedge clk)
        !rst_n |=> !busy && !tx_valid && !tx_done && len_rd == '0);

endmodule

// File: tb/tx_frame_buffer_test.sv
module tx_frame_buffer_test;

    localparam int CAP = 1514;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        len_wr = 1'b0;
    logic [15:0] len_wdata = '0;
    logic [10:0] len_rd;
    logic        byte_wr = 1'b0;
    logic [7:0]  byte_wdata = '0;
    logic        busy;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b1;
    logic        tx_done;

    always #10 clk = ~clk;

    tx_frame_buffer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_wr     (len_wr),
        .len_wdata  (len_wdata),
        .len_rd     (len_rd),
        .byte_wr    (byte_wr),
        .byte_wdata (byte_wdata),
        .busy       (busy),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready),
        .tx_done    (tx_done)
    );

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          finished = 1'b0;
    bit          stall    = 1'b0;

    // behavioural reference
    logic [7:0] fill_q[$];
    logic [7:0] out_q[$];
    int         m_len  = 0;
    bit         m_busy = 1'b0;
    bit         m_done = 1'b0;
    int         beats  = 0;
    int         last_len = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            fill_q.delete(); out_q.delete();
            m_len = 0; m_busy = 1'b0; m_done = 1'b0;
        end else begin
            bit nd;
            bit fire;
            nd = 1'b0;
            fire = 1'b0;
            if (m_busy) begin
                if (tx_ready) begin
                    void'(out_q.pop_front());
                    if (out_q.size() == 0) begin
                        m_busy = 1'b0;
                        nd = 1'b1;
                    end
                end
            end else if (byte_wr) begin
                fill_q.push_back(byte_wdata);
                if (fill_q.size() == CAP || fill_q.size() == m_len) fire = 1'b1;
            end
            if (fire) begin
                out_q = fill_q;
                fill_q.delete();
                m_busy = 1'b1;
                m_len = 0;
            end
            if (len_wr) m_len = (int'(len_wdata) <= CAP) ? int'(len_wdata) : 0;
            m_done = nd;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(int'(len_rd) == m_len, "R1,R2,R6,R11 len_rd", int'(len_rd), m_len);
            check(busy == m_busy, "R7 busy", busy, m_busy);
            check(tx_valid == m_busy, "R7,R8 tx_valid", tx_valid, m_busy);
            check(tx_done == m_done, "R10 tx_done", tx_done, m_done);
            if (m_busy && tx_valid) begin
                check(tx_data == out_q[0], "R3,R8 tx_data", tx_data, out_q[0]);
                check(tx_last == (out_q.size() == 1), "R9 tx_last", tx_last, out_q.size() == 1);
            end
            if (tx_valid && tx_ready) begin
                beats++;
                if (tx_last) begin
                    last_len = beats;
                    beats = 0;
                end
            end
        end
    end

    initial begin
        logic [7:0] lf;
        lf = 8'hA5;
        forever begin
            @(posedge clk);
            #1;
            tx_ready = stall ? (lf[0] ^ lf[3]) : 1'b1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        end
    end

    task automatic set_len(input int v);
        len_wr = 1'b1;
        len_wdata = 16'(v);
        @(posedge clk); #1;
        len_wr = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v);
        byte_wr = 1'b1;
        byte_wdata = v;
        @(posedge clk); #1;
        byte_wr = 1'b0;
    endtask

    task automatic wait_done();
        while (!tx_done) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #5;
        // R12 reset state
        check(len_rd == '0, "R12 len_rd", len_rd, 0);
        check(!busy && !tx_valid && !tx_done, "R12 idle", {busy, tx_valid, tx_done}, 0);
        @(posedge clk); #1;

        // R4 basic frame of four
        set_len(4);
        for (int i = 0; i < 4; i++) put_byte(8'(8'h10 + i));
        wait_done();
        check(last_len == 4, "R4 frame length", last_len, 4);

        // R1 / R2 range handling
        set_len(2000);
        #5 check(len_rd == '0, "R2 len 2000", len_rd, 0);
        @(posedge clk); #1;
        set_len(1515);
        #5 check(len_rd == '0, "R2 len 1515", len_rd, 0);
        @(posedge clk); #1;
        set_len(1514);
        #5 check(int'(len_rd) == 1514, "R1 len 1514", len_rd, 1514);
        @(posedge clk); #1;

        // R7, R8: stalled stream with writes while busy
        stall = 1'b1;
        set_len(6);
        for (int i = 0; i < 6; i++) put_byte(8'(8'h40 + 3 * i));
        for (int i = 0; i < 3; i++) put_byte(8'hEE);
        wait_done();
        check(last_len == 6, "R4,R7 frame length", last_len, 6);
        stall = 1'b0;
        @(posedge clk); #1;

        // R6: next frame starts at position zero
        set_len(3);
        for (int i = 0; i < 3; i++) put_byte(8'(8'hA0 + i));
        wait_done();
        check(last_len == 3, "R6 frame length", last_len, 3);

        // R9: single-byte frame
        set_len(1);
        put_byte(8'h5A);
        wait_done();
        check(last_len == 1, "R9 single byte", last_len, 1);

        // R11: length write coinciding with the sending write
        set_len(3);
        put_byte(8'h01);
        put_byte(8'h02);
        byte_wr = 1'b1; byte_wdata = 8'h03;
        len_wr = 1'b1;  len_wdata = 16'd5;
        @(posedge clk); #1;
        byte_wr = 1'b0; len_wr = 1'b0;
        #5 check(int'(len_rd) == 5, "R11 kept length", len_rd, 5);
        wait_done();
        check(last_len == 3, "R11 first frame", last_len, 3);
        for (int i = 0; i < 5; i++) put_byte(8'(8'hC0 + i));
        wait_done();
        check(last_len == 5, "R11 second frame", last_len, 5);

        // R5: zero length fills to capacity
        set_len(0);
        for (int i = 0; i < CAP - 1; i++) put_byte(8'(i * 7));
        #5 check(!busy, "R5 no send before capacity", busy, 0);
        @(posedge clk); #1;
        put_byte(8'hF0);
        wait_done();
        check(last_len == CAP, "R5 capacity frame", last_len, CAP);

        repeat (4) @(posedge clk);
        #1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

endmodule